// File: doc/BRIEF.md
# Shared Receive Packet Queue

This block is the single receive buffer of a USB host controller. Every IN transaction lands in it, periodic and nonperiodic alike. A link engine offers each received packet as a header (channel number, byte count and packet status) followed by its payload in 32-bit words. The block stores one tagged status word for the packet and then the payload words, all in one storage array, so a single popper sees packets strictly in arrival order.

A packet is admitted only when the free space covers its status word and all of its payload words at once. Otherwise the packet is refused: a one-cycle drop pulse is raised and the payload words the engine still delivers for it are swallowed. On the read side the head word is visible without a pop request. A flag marks whether the head is a status word, so the reader can decode the byte count and pop exactly that many payload words. The block also reports its fill level, full and empty.

Top module: `rxq_shared_fifo`

## Requirements
- R1: After reset rd_empty=1, rd_full=0, rd_level=0, rd_is_status=0, wr_busy=0 and pkt_drop=0.
- R2: A status word reads as channel in bits [3:0], byte count in bits [14:4], packet status in bits [16:15] (00 data good, 01 data error, 10 transfer complete) and zeros above.
- R3: An admitted packet with byte count B reads out as its status word followed by ceil(B/4) payload words in write order. rd_is_status is 1 exactly when the head is a status word.
- R4: A packet with byte count 0 stores only its status word, and wr_busy stays 0.
- R5: A packet is admitted if and only if 1 + ceil(B/4) is no greater than 2^AW minus rd_level in the pkt_start cycle. An exact fit is admitted.
- R6: A refused packet raises pkt_drop for one cycle right after the pkt_start edge and leaves rd_level unchanged. Its ceil(B/4) payload words are discarded while wr_busy is 1.
- R7: rd_pop while rd_empty is 1 is ignored: the level stays 0 and later data is unaffected.
- R8: rd_level counts stored words. rd_full is 1 at the full depth. A push and a pop in the same cycle keep the level.
- R9: pkt_start while wr_busy is 1 is ignored, and wr_valid while wr_busy is 0 is ignored.
- R10: Packets from different channels are read out in the order they were started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Offers a new packet header |
| pkt_chan | input | 4 | Channel number of the offered packet |
| pkt_bcnt | input | 11 | Byte count of the offered packet |
| pkt_stat | input | 2 | Packet status of the offered packet |
| wr_valid | input | 1 | Payload word strobe |
| wr_data | input | 32 | Payload word |
| wr_busy | output | 1 | Payload of the current packet still expected |
| pkt_drop | output | 1 | One-cycle pulse: packet refused |
| rd_pop | input | 1 | Removes the head word |
| rd_data | output | 32 | Head word |
| rd_is_status | output | 1 | Head word is a status word |
| rd_empty | output | 1 | No word stored |
| rd_full | output | 1 | All words in use |
| rd_level | output | 7 | Number of stored words |

## Verification
The bench fills the queue to exactly its depth with one packet and then to one word short of a second packet's need. An off-by-one in the room check would either refuse the exact fit or overrun the storage. After a refusal it feeds the refused packet's payload and then reads back. A design that stored those words, or that stopped skipping too early or too late, would shift every later status word out of place. It also pops an empty queue, starts a packet in the middle of another packet's payload, and pushes and pops in the same cycle. Each of these exposes pointer or level corruption as wrong data or a wrong level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    PKT_GOOD  = 2'b00,
    PKT_ERROR = 2'b01,
    XFER_DONE = 2'b10,
    PKT_RSVD  = 2'b11
  } pkt_stat_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'b00,
    WS_FILL = 2'b01,
    WS_SKIP = 2'b10
  } wr_state_e;

  // payload words needed for a byte count, rounded up to whole words
  function automatic logic [15:0] payload_words(input logic [15:0] bytes);
    logic [16:0] sum;
    sum = 17'(bytes) + 17'd3;
    return 16'(sum >> 2);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W:0]   push_word,
  input  logic              pop,
  output logic [DATA_W:0]   head_word,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full
);

  logic [DATA_W:0]  mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             pop_eff;
  logic             ptr_en;

  assign empty   = (level_q == '0);
  assign full    = (level_q == LVL_W'(DEPTH));
  assign pop_eff = pop && !empty;
  assign ptr_en  = push || pop_eff;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (push)    wr_ptr_d = wr_ptr_q + AW'(1);
    if (pop_eff) rd_ptr_d = rd_ptr_q + AW'(1);
    if (push && !pop_eff)      level_d = level_q + LVL_W'(1);
    else if (!push && pop_eff) level_d = level_q - LVL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= push_word;
  end

  assign head_word = mem_q[rd_ptr_q];
  assign level     = level_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |-> pop)
    else $error("push into a full store");

  assert_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (level == '0))
    else $error("pop on empty changed level");

  assert_level_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(level))
    else $error("simultaneous push and pop moved level");

endmodule

// File: rtl/rxq_admit.sv
module rxq_admit
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CH_W   = 4,
  parameter int BC_W   = 11,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic [CH_W-1:0]   pkt_chan,
  input  logic [BC_W-1:0]   pkt_bcnt,
  input  logic [1:0]        pkt_stat,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LVL_W-1:0]  level,
  output logic              push,
  output logic [DATA_W:0]   push_word,
  output logic              busy,
  output logic              pkt_drop
);

  wr_state_e       state_q, state_d;
  logic [BC_W-1:0] remain_q, remain_d;
  logic            drop_q, drop_d;
  logic [15:0]     words;
  logic            fits;
  logic [DATA_W-1:0] status_word;
  logic            run_en;

  always_comb begin
    words = payload_words(16'(pkt_bcnt));
    fits  = (int'(words) + 1) <= (DEPTH - int'(level));
    status_word = '0;
    status_word[CH_W-1:0]        = pkt_chan;
    status_word[CH_W +: BC_W]    = pkt_bcnt;
    status_word[CH_W+BC_W +: 2]  = pkt_stat;
  end

  always_comb begin
    state_d   = state_q;
    remain_d  = remain_q;
    drop_d    = 1'b0;
    push      = 1'b0;
    push_word = '0;
    unique case (state_q)
      WS_IDLE: begin
        if (pkt_start) begin
          remain_d = BC_W'(words);
          if (fits) begin
            push      = 1'b1;
            push_word = {1'b1, status_word};
            if (words != '0) state_d = WS_FILL;
          end else begin
            drop_d = 1'b1;
            if (words != '0) state_d = WS_SKIP;
          end
        end
      end
      WS_FILL: begin
        if (wr_valid) begin
          push      = 1'b1;
          push_word = {1'b0, wr_data};
          remain_d  = remain_q - BC_W'(1);
          if (remain_q == BC_W'(1)) state_d = WS_IDLE;
        end
      end
      WS_SKIP: begin
        if (wr_valid) begin
          remain_d = remain_q - BC_W'(1);
          if (remain_q == BC_W'(1)) state_d = WS_IDLE;
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  assign run_en = pkt_start || wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WS_IDLE;
      remain_q <= '0;
    end else if (run_en) begin
      state_q  <= state_d;
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= drop_d;
  end

  assign busy     = (state_q != WS_IDLE);
  assign pkt_drop = drop_q;

  assert_drop_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_drop |-> $past(pkt_start))
    else $error("drop pulse without a packet start");

  assert_no_status_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && push) |-> !push_word[DATA_W])
    else $error("status word written during payload phase");

  assert_fill_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (remain_q != '0))
    else $error("busy with no payload outstanding");

endmodule

// File: rtl/rxq_shared_fifo.sv
module rxq_shared_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int CH_W   = 4,
  parameter int BC_W   = 11,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic [CH_W-1:0]   pkt_chan,
  input  logic [BC_W-1:0]   pkt_bcnt,
  input  logic [1:0]        pkt_stat,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_busy,
  output logic              pkt_drop,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_is_status,
  output logic              rd_empty,
  output logic              rd_full,
  output logic [LVL_W-1:0]  rd_level
);

  logic            push;
  logic [DATA_W:0] push_word;
  logic [DATA_W:0] head_word;

  rxq_admit #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .CH_W(CH_W), .BC_W(BC_W)
  ) u_admit (
    .clk(clk), .rst_n(rst_n),
    .pkt_start(pkt_start), .pkt_chan(pkt_chan), .pkt_bcnt(pkt_bcnt),
    .pkt_stat(pkt_stat), .wr_valid(wr_valid), .wr_data(wr_data),
    .level(rd_level), .push(push), .push_word(push_word),
    .busy(wr_busy), .pkt_drop(pkt_drop)
  );

  rxq_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_word(push_word), .pop(rd_pop),
    .head_word(head_word), .level(rd_level),
    .empty(rd_empty), .full(rd_full)
  );

  assign rd_data      = head_word[DATA_W-1:0];
  assign rd_is_status = !rd_empty && head_word[DATA_W];

  assert_drop_keeps_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_drop && !rd_pop) |-> $stable(rd_level))
    else $error("refused packet changed the level");

endmodule

// File: tb/test_rxq_shared_fifo.sv
module test_rxq_shared_fifo;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pkt_start, wr_valid, rd_pop;
  logic [3:0]  pkt_chan;
  logic [10:0] pkt_bcnt;
  logic [1:0]  pkt_stat;
  logic [31:0] wr_data;
  logic        wr_busy, pkt_drop, rd_is_status, rd_empty, rd_full;
  logic [31:0] rd_data;
  logic [6:0]  rd_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  rxq_shared_fifo i_rxq_shared_fifo (
    .clk(clk), .rst_n(rst_n),
    .pkt_start(pkt_start), .pkt_chan(pkt_chan), .pkt_bcnt(pkt_bcnt),
    .pkt_stat(pkt_stat), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_busy(wr_busy), .pkt_drop(pkt_drop), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_is_status(rd_is_status), .rd_empty(rd_empty),
    .rd_full(rd_full), .rd_level(rd_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word(input logic [3:0] ch, input logic [10:0] bc,
                                            input logic [1:0] st);
    return {15'd0, st, bc, ch};
  endfunction

  task automatic start_pkt(input logic [3:0] ch, input logic [10:0] bc,
                           input logic [1:0] st, output logic dropped);
    @(negedge clk);
    pkt_start = 1'b1; pkt_chan = ch; pkt_bcnt = bc; pkt_stat = st;
    @(negedge clk);
    pkt_start = 1'b0;
    dropped = pkt_drop;
  endtask

  task automatic put_word(input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [3:0] ch, input logic [10:0] bc,
                          input logic [1:0] st, input logic [31:0] base);
    logic dr;
    start_pkt(ch, bc, st, dr);
    for (int i = 0; i < (int'(bc) + 3) / 4; i++) put_word(base + 32'(i));
  endtask

  task automatic take(input logic [31:0] exp, input logic exp_st, input string req);
    @(negedge clk);
    check(req, {31'd0, rd_is_status}, {31'd0, exp_st});
    check(req, rd_data, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic drain_pkt(input logic [3:0] ch, input logic [10:0] bc,
                           input logic [1:0] st, input logic [31:0] base, input string req);
    take(stat_word(ch, bc, st), 1'b1, req);
    for (int i = 0; i < (int'(bc) + 3) / 4; i++) take(base + 32'(i), 1'b0, req);
  endtask

  task automatic t_reset;
    check("R1 empty", {31'd0, rd_empty}, 32'd1);
    check("R1 full", {31'd0, rd_full}, 32'd0);
    check("R1 level", {25'd0, rd_level}, 32'd0);
    check("R1 is_status", {31'd0, rd_is_status}, 32'd0);
    check("R1 busy", {31'd0, wr_busy}, 32'd0);
    check("R1 drop", {31'd0, pkt_drop}, 32'd0);
  endtask

  task automatic t_single;
    send_pkt(4'd5, 11'd10, 2'b01, 32'hA500_0000);
    check("R3 level", {25'd0, rd_level}, 32'd4);
    check("R2 status format", rd_data, 32'h0000_80A5);
    drain_pkt(4'd5, 11'd10, 2'b01, 32'hA500_0000, "R3 single packet");
    check("R3 empty after", {31'd0, rd_empty}, 32'd1);
  endtask

  task automatic t_zero_len;
    logic dr;
    start_pkt(4'd15, 11'd0, 2'b10, dr);
    check("R4 busy", {31'd0, wr_busy}, 32'd0);
    check("R4 level", {25'd0, rd_level}, 32'd1);
    take(32'h0001_000F, 1'b1, "R4 zero length status");
    check("R4 empty", {31'd0, rd_empty}, 32'd1);
  endtask

  task automatic t_order;
    send_pkt(4'd1, 11'd4, 2'b00, 32'h1100_0000);
    send_pkt(4'd2, 11'd5, 2'b10, 32'h2200_0000);
    check("R10 level", {25'd0, rd_level}, 32'd5);
    drain_pkt(4'd1, 11'd4, 2'b00, 32'h1100_0000, "R10 first packet");
    drain_pkt(4'd2, 11'd5, 2'b10, 32'h2200_0000, "R10 second packet");
  endtask

  task automatic t_exact_fit;
    logic dr;
    send_pkt(4'd3, 11'd252, 2'b00, 32'h3300_0000);
    check("R5 exact fit level", {25'd0, rd_level}, 32'd64);
    check("R8 full", {31'd0, rd_full}, 32'd1);
    start_pkt(4'd4, 11'd0, 2'b00, dr);
    check("R6 drop on full", {31'd0, dr}, 32'd1);
    check("R6 level kept", {25'd0, rd_level}, 32'd64);
    @(negedge clk);
    check("R6 drop one cycle", {31'd0, pkt_drop}, 32'd0);
    drain_pkt(4'd3, 11'd252, 2'b00, 32'h3300_0000, "R5 exact fit data");
    check("R8 empty after drain", {31'd0, rd_empty}, 32'd1);
  endtask

  task automatic t_reject_skip;
    logic dr;
    send_pkt(4'd6, 11'd236, 2'b00, 32'h6600_0000);
    check("R5 level 60", {25'd0, rd_level}, 32'd60);
    start_pkt(4'd7, 11'd13, 2'b01, dr);
    check("R5 one word short refused", {31'd0, dr}, 32'd1);
    check("R6 busy while skipping", {31'd0, wr_busy}, 32'd1);
    for (int i = 0; i < 4; i++) put_word(32'hDEAD_0000 + 32'(i));
    check("R6 skipped payload not stored", {25'd0, rd_level}, 32'd60);
    check("R6 busy cleared", {31'd0, wr_busy}, 32'd0);
    start_pkt(4'd8, 11'd12, 2'b10, dr);
    check("R5 exact remaining fit", {31'd0, dr}, 32'd0);
    for (int i = 0; i < 3; i++) put_word(32'h8800_0000 + 32'(i));
    check("R8 full again", {31'd0, rd_full}, 32'd1);
    drain_pkt(4'd6, 11'd236, 2'b00, 32'h6600_0000, "R6 packet before refusal");
    drain_pkt(4'd8, 11'd12, 2'b10, 32'h8800_0000, "R6 packet after refusal");
  endtask

  task automatic t_pop_empty;
    logic dr;
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
    check("R7 level after empty pop", {25'd0, rd_level}, 32'd0);
    check("R7 still empty", {31'd0, rd_empty}, 32'd1);
    start_pkt(4'd12, 11'd0, 2'b00, dr);
    take(stat_word(4'd12, 11'd0, 2'b00), 1'b1, "R7 data after empty pop");
  endtask

  task automatic t_busy_ignore;
    logic dr;
    put_word(32'hBAD0_BAD0);
    check("R9 idle payload ignored", {25'd0, rd_level}, 32'd0);
    start_pkt(4'd9, 11'd8, 2'b00, dr);
    start_pkt(4'd10, 11'd0, 2'b00, dr);
    check("R9 start while busy no drop", {31'd0, dr}, 32'd0);
    check("R9 start while busy not stored", {25'd0, rd_level}, 32'd1);
    put_word(32'h9900_0000);
    put_word(32'h9900_0001);
    check("R9 level", {25'd0, rd_level}, 32'd3);
    drain_pkt(4'd9, 11'd8, 2'b00, 32'h9900_0000, "R9 packet intact");
    check("R9 empty", {31'd0, rd_empty}, 32'd1);
  endtask

  task automatic t_simul;
    logic dr;
    start_pkt(4'd11, 11'd8, 2'b00, dr);
    put_word(32'hB000_0000);
    check("R8 level before", {25'd0, rd_level}, 32'd2);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 32'hB000_0001; rd_pop = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_pop = 1'b0;
    check("R8 push and pop keep level", {25'd0, rd_level}, 32'd2);
    take(32'hB000_0000, 1'b0, "R8 after simultaneous");
    take(32'hB000_0001, 1'b0, "R8 after simultaneous");
    check("R8 empty", {31'd0, rd_empty}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pkt_start = 1'b0; wr_valid = 1'b0; rd_pop = 1'b0;
    pkt_chan = '0; pkt_bcnt = '0; pkt_stat = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_zero_len;
    t_order;
    t_exact_fit;
    t_reject_skip;
    t_pop_empty;
    t_busy_ignore;
    t_simul;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule